// File: doc/BRIEF.md
# Execute-Stage Dependency Interlock

This block decides, for each instruction about to enter the execute section of a scalar in-order pipeline, whether it may go ahead and where its two operands come from. Single-cycle operations spend one cycle in execute. Multi-cycle operations pass through a chain of `EX_STAGES` execute stages and produce their result only at the end of the last one. The interlock keeps a shift record of the destination register and latency class of every instruction that entered execute in the last `EX_STAGES` cycles. It compares both source registers of the incoming instruction against that record. For each source the youngest matching producer decides the outcome. If that producer is a one-cycle operation that entered execute in the previous cycle, the operand is taken from the execute result just produced. If it is a multi-cycle operation still inside its chain, the incoming instruction is held. If it is a multi-cycle operation that has just left its last stage, the operand is forwarded. In every other case the operand is read from the register file.

While the incoming instruction is held, an empty slot enters execute in its place and the instruction stays at the interlock's input. Upstream logic must keep it there unchanged until the stall is released. Register index 0 is a constant and never creates a dependency. With the default of three execute stages, a consumer that follows a multi-cycle producer at a distance of three issue slots runs without any stall.

Top module: `hz_interlock`

## Requirements
- R1: After reset the record of in-flight instructions is empty, so any presented instruction gets stall 0 and both selects 0 (0 = register file, 1 = execute result just produced).
- R2: A source matching the destination of a one-cycle operation (`in_multi` = 0) that issued in the immediately preceding cycle gets select 1 and causes no stall.
- R3: A source whose youngest producer is a one-cycle operation that issued two or more cycles earlier gets select 0 and causes no stall.
- R4: When a source's youngest producer is a multi-cycle operation (`in_multi` = 1) that issued k cycles earlier, the instruction stalls for k < `EX_STAGES`. It proceeds with select 1 when k = `EX_STAGES`, and with select 0 when k > `EX_STAGES`.
- R5: A held instruction is released after exactly `EX_STAGES` − k stall cycles, so no run of consecutive stalls is longer than `EX_STAGES` − 1 cycles. Only an instruction that proceeds enters the record; each stall cycle inserts an empty slot.
- R6: Register 0 is never a dependency. Reading it never stalls and always gives select 0, and writing it is never recorded.
- R7: When several recorded producers write the same register, only the youngest one decides the stall and the select.
- R8: The two sources are checked independently, each with its own select, and the instruction stalls if either source requires it.
- R9: When `in_valid` is 0 the stall output is 0 and the presented instruction is not recorded.
- R10: Both selects are 0 in any cycle where no instruction proceeds (`in_valid` 0 or stall 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented for execute |
| in_src_a | input | HZ_IDX_W | First source register index |
| in_src_b | input | HZ_IDX_W | Second source register index |
| in_dst | input | HZ_IDX_W | Destination register index (0 = no write) |
| in_multi | input | 1 | Latency class: 1 = multi-cycle chain, 0 = one cycle |
| out_stall | output | 1 | Hold the presented instruction; an empty slot enters execute |
| out_fwd_a | output | 1 | First source takes the just-produced execute result |
| out_fwd_b | output | 1 | Second source takes the just-produced execute result |

## Verification
The assertions assume that a held instruction stays unchanged at the input for as long as the stall lasts. The bound on stall length and the next-cycle stall and forward properties depend on this. The directed tasks always keep the same fields driven until the stall drops, and they only change the inputs in the cycle after the instruction proceeds. Each scenario starts with enough idle cycles to empty the record, so a consumer's distance from its producer is fully set by the fillers that the task inserts.

// File: rtl/hz_pkg.sv
package hz_pkg;

    parameter int unsigned HZ_NUM_REGS = 32;
    localparam int unsigned HZ_IDX_W   = $clog2(HZ_NUM_REGS);

    typedef logic [HZ_IDX_W-1:0] reg_idx_t;

    typedef enum logic {
        LAT_ONE   = 1'b0,
        LAT_MULTI = 1'b1
    } lat_e;

    typedef enum logic {
        SRC_REGFILE = 1'b0,
        SRC_EXFWD   = 1'b1
    } fwd_e;

    // One occupied (or empty) execute slot.
    typedef struct packed {
        logic     live;
        reg_idx_t dst;
        lat_e     lat;
    } slot_t;

    // Per-source decision.
    typedef struct packed {
        logic hold;
        fwd_e sel;
    } verdict_t;

    function automatic logic hz_depends(input reg_idx_t src, input slot_t s);
        return s.live && (src != '0) && (s.dst == src);
    endfunction

endpackage

// File: rtl/hz_track.sv
module hz_track
    import hz_pkg::*;
#(
    parameter int unsigned DEPTH = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  slot_t                  push,
    output slot_t [DEPTH-1:0]      slots
);

    // slots[i] holds the instruction that entered execute i+1 cycles ago.
    always_ff @(posedge clk) begin
        if (rst) begin
            slots <= '0;
        end else begin
            slots[0] <= push;
            for (int i = 1; i < int'(DEPTH); i++) begin
                slots[i] <= slots[i-1];
            end
        end
    end

endmodule

// File: rtl/hz_match.sv
module hz_match
    import hz_pkg::*;
#(
    parameter int unsigned DEPTH = 3
) (
    input  reg_idx_t              src,
    input  slot_t [DEPTH-1:0]     slots,
    output verdict_t              verdict
);

    localparam int LAST = int'(DEPTH) - 1;

    // Scan oldest to youngest so the youngest match is written last.
    always_comb begin
        verdict.hold = 1'b0;
        verdict.sel  = SRC_REGFILE;
        for (int i = LAST; i >= 0; i--) begin
            if (hz_depends(src, slots[i])) begin
                if (slots[i].lat == LAT_MULTI) begin
                    verdict.hold = (i != LAST);
                    verdict.sel  = (i == LAST) ? SRC_EXFWD : SRC_REGFILE;
                end else begin
                    verdict.hold = 1'b0;
                    verdict.sel  = (i == 0) ? SRC_EXFWD : SRC_REGFILE;
                end
            end
        end
    end

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
    import hz_pkg::*;
#(
    parameter int unsigned EX_STAGES = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [HZ_IDX_W-1:0] in_src_a,
    input  logic [HZ_IDX_W-1:0] in_src_b,
    input  logic [HZ_IDX_W-1:0] in_dst,
    input  logic                in_multi,
    output logic                out_stall,
    output logic                out_fwd_a,
    output logic                out_fwd_b
);

    localparam int unsigned NSRC = 2;

    slot_t [EX_STAGES-1:0] slots;
    slot_t                 push;
    reg_idx_t              srcs     [NSRC];
    verdict_t              verdicts [NSRC];
    logic                  issue;

    assign srcs[0] = in_src_a;
    assign srcs[1] = in_src_b;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        hz_match #(.DEPTH(EX_STAGES)) u_match (
            .src     (srcs[s]),
            .slots   (slots),
            .verdict (verdicts[s])
        );
    end

    assign out_stall = in_valid && (verdicts[0].hold || verdicts[1].hold);
    assign issue     = in_valid && !out_stall;

    assign out_fwd_a = issue && (verdicts[0].sel == SRC_EXFWD);
    assign out_fwd_b = issue && (verdicts[1].sel == SRC_EXFWD);

    // A stalled or absent instruction becomes an empty slot (bubble).
    always_comb begin
        push.live = issue && (in_dst != '0);
        push.dst  = in_dst;
        push.lat  = lat_e'(in_multi);
    end

    hz_track #(.DEPTH(EX_STAGES)) u_track (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .slots (slots)
    );

endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk
    import hz_pkg::*;
#(
    parameter int unsigned EX_STAGES = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [HZ_IDX_W-1:0] in_src_a,
    input logic [HZ_IDX_W-1:0] in_src_b,
    input logic [HZ_IDX_W-1:0] in_dst,
    input logic                in_multi,
    input logic                out_stall,
    input logic                out_fwd_a,
    input logic                out_fwd_b
);

    localparam int unsigned RUN_W = $clog2(EX_STAGES + 1) + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(EX_STAGES);

    logic             seen;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen  <= 1'b0;
            run_q <= '0;
        end else begin
            seen  <= 1'b1;
            if (!out_stall)            run_q <= '0;
            else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
        end
    end

    assert_idle_no_stall_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !out_stall);

    assert_hold_selects_rf_R10: assert property (@(posedge clk) disable iff (rst)
        (!in_valid || out_stall) |-> (!out_fwd_a && !out_fwd_b));

    assert_zero_src_a_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_src_a == '0) |-> !out_fwd_a);

    assert_zero_src_b_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_src_b == '0) |-> !out_fwd_b);

    assert_multi_next_stall_R4: assert property (@(posedge clk) disable iff (rst)
        (EX_STAGES >= 2 && seen && $past(in_valid && !out_stall && in_multi && in_dst != '0)
         && in_valid && in_src_a == $past(in_dst)) |-> out_stall);

    assert_single_next_fwd_R2: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(in_valid && !out_stall && !in_multi && in_dst != '0)
         && in_valid && !out_stall && in_src_a == $past(in_dst)) |-> out_fwd_a);

    assert_stall_bound_R5: assert property (@(posedge clk) disable iff (rst)
        out_stall |-> (run_q < RUN_W'(EX_STAGES - 1)));

endmodule

bind hz_interlock hz_interlock_chk #(.EX_STAGES(EX_STAGES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_src_a  (in_src_a),
    .in_src_b  (in_src_b),
    .in_dst    (in_dst),
    .in_multi  (in_multi),
    .out_stall (out_stall),
    .out_fwd_a (out_fwd_a),
    .out_fwd_b (out_fwd_b)
);

// File: tb/tb_hz_interlock.sv
module tb_hz_interlock;
    import hz_pkg::*;

    localparam int C = 3;

    logic                clk = 1'b0;
    logic                rst;
    logic                in_valid;
    logic [HZ_IDX_W-1:0] in_src_a, in_src_b, in_dst;
    logic                in_multi;
    logic                out_stall, out_fwd_a, out_fwd_b;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    hz_interlock #(.EX_STAGES(C)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
        .in_multi(in_multi), .out_stall(out_stall),
        .out_fwd_a(out_fwd_a), .out_fwd_b(out_fwd_b)
    );

    task automatic put(input logic v, input int a, input int b, input int d, input logic m);
        in_valid = v;
        in_src_a = HZ_IDX_W'(a);
        in_src_b = HZ_IDX_W'(b);
        in_dst   = HZ_IDX_W'(d);
        in_multi = m;
    endtask

    task automatic nxt;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic es, input logic ea, input logic eb, input string tag);
        #1;
        checks++;
        if (out_stall !== es || out_fwd_a !== ea || out_fwd_b !== eb) begin
            failures++;
            $display("FAIL %s: got stall=%b fa=%b fb=%b, expected stall=%b fa=%b fb=%b",
                     tag, out_stall, out_fwd_a, out_fwd_b, es, ea, eb);
        end
    endtask

    task automatic flush;
        put(1'b0, 0, 0, 0, 1'b0);
        repeat (C + 1) nxt();
    endtask

    task automatic t_reset;
        put(1'b0, 0, 0, 0, 1'b0);
        chk(1'b0, 1'b0, 1'b0, "R1 idle");
        put(1'b1, 1, 2, 3, 1'b0);
        chk(1'b0, 1'b0, 1'b0, "R1 first instruction");
        put(1'b0, 0, 0, 0, 1'b0);
        nxt();
    endtask

    task automatic t_single;
        flush();
        put(1'b1, 0, 0, 5, 1'b0); nxt();
        put(1'b1, 5, 0, 6, 1'b0);
        chk(1'b0, 1'b1, 1'b0, "R2 adjacent one-cycle producer");
        nxt();
        put(1'b1, 6, 5, 0, 1'b0);
        chk(1'b0, 1'b1, 1'b0, "R3 older one-cycle producer on b");
        nxt();
    endtask

    task automatic t_multi_gap(input int k);
        flush();
        put(1'b1, 0, 0, 3, 1'b1); nxt();
        for (int f = 1; f < k; f++) begin
            put(1'b1, 0, 0, 0, 1'b0); nxt();
        end
        put(1'b1, 3, 0, 0, 1'b0);
        for (int j = 0; j < C - k; j++) begin
            chk(1'b1, 1'b0, 1'b0, $sformatf("R4 R10 stall k=%0d cycle %0d", k, j));
            nxt();
        end
        chk(1'b0, (k <= C) ? 1'b1 : 1'b0, 1'b0, $sformatf("R4 R5 release k=%0d", k));
        nxt();
    endtask

    task automatic t_zero;
        flush();
        put(1'b1, 0, 0, 0, 1'b1); nxt();
        put(1'b1, 0, 0, 7, 1'b0);
        chk(1'b0, 1'b0, 1'b0, "R6 register 0");
        nxt();
    endtask

    task automatic t_youngest;
        flush();
        put(1'b1, 0, 0, 7, 1'b1); nxt();
        put(1'b1, 0, 0, 7, 1'b0); nxt();
        put(1'b1, 7, 0, 0, 1'b0);
        chk(1'b0, 1'b1, 1'b0, "R7 younger one-cycle wins");
        nxt();
        flush();
        put(1'b1, 0, 0, 7, 1'b0); nxt();
        put(1'b1, 0, 0, 7, 1'b1); nxt();
        put(1'b1, 7, 0, 0, 1'b0);
        chk(1'b1, 1'b0, 1'b0, "R7 younger multi-cycle wins");
        nxt();
        chk(1'b1, 1'b0, 1'b0, "R7 still held");
        nxt();
        chk(1'b0, 1'b1, 1'b0, "R7 release");
        nxt();
    endtask

    task automatic t_two_src;
        flush();
        put(1'b1, 0, 0, 13, 1'b1); nxt();
        put(1'b1, 0, 0, 12, 1'b0); nxt();
        put(1'b1, 12, 13, 0, 1'b0);
        chk(1'b1, 1'b0, 1'b0, "R8 b forces stall");
        nxt();
        chk(1'b0, 1'b0, 1'b1, "R8 independent selects");
        nxt();
    endtask

    task automatic t_invalid;
        flush();
        put(1'b0, 0, 0, 6, 1'b1); nxt();
        put(1'b1, 6, 0, 0, 1'b0);
        chk(1'b0, 1'b0, 1'b0, "R9 invalid not recorded");
        nxt();
        flush();
        put(1'b1, 0, 0, 4, 1'b1); nxt();
        put(1'b0, 4, 4, 0, 1'b0);
        chk(1'b0, 1'b0, 1'b0, "R9 R10 invalid consumer");
        nxt();
    endtask

    initial begin
        put(1'b0, 0, 0, 0, 1'b0);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        for (int k = 1; k <= C + 1; k++) t_multi_gap(k);
        t_zero();
        t_youngest();
        t_two_src();
        t_invalid();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule